// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block decides where a load's data should come from. A load arrives with its address, its byte count and the store-queue position it was allocated behind. The block then walks the store queue one entry at a time toward older stores. It reads each entry through a synchronous read port and stops at the first store that overlaps the load.

There are three possible outcomes:

- **Full cover.** If that store holds all of the load's bytes, the bytes are returned as a forwarded result.
- **Partial cover.** If the store holds only some of the bytes, the load is sent back for replay. The block keeps a record of the oldest such load and the store it waits on.
- **No overlap.** If no store overlaps before the walk reaches the writeback position, the block asks for a cache read. The read is a load-locked read when the load is a linked access.

The stall record stays set until the blocking store reports completion. At that point the block emits a release pulse naming the held load. Two counters track how many loads were forwarded and how many were sent for replay.

Top module: `stld_fwd_check`

## Requirements
- R1: While reset is high, and after it, the outputs are idle: `ld_ready`=1, `res_valid`=0, `stall_active`=0, `rel_valid`=0, and both counters are zero.
- R2: The walk examines positions `ld_stq_pos`-1, then -2, and so on, wrapping from 0 to `STQ_DEPTH`-1. The outcome is decided by the first eligible store that overlaps the load, even when an older store would fully cover it.
- R3: The walk never goes past `wb_pos`, which is the last position examined. If `ld_stq_pos` equals `wb_pos`, no entry is examined and the result is a cache read, one cycle after acceptance.
- R4: An entry whose size is zero, or whose uncacheable flag is set, never affects the outcome.
- R5: A store covers the load fully when its start is at or below the load address and its end is at or above the load end. Each address range is start plus size, in bytes.
  - In that case `res_kind`=1 (forward).
  - Byte i of `res_data` is store byte (load address − store address + i) for i below the load size, and zero above it.
- R6: A partial overlap gives `res_kind`=2 (replay), with `res_ldq_pos` equal to the load's queue position.
- R7: On a replay, the stall record (blocking store sequence number and load position) is taken when no stall is held. When a stall is held, the record is replaced only if the new load's sequence number is smaller, meaning the load is older.
- R8: When `st_done_valid` is high and `st_done_seq` matches the recorded store, the stall clears and `rel_valid` pulses for one cycle with `rel_ldq_pos` equal to the held load. A completion with any other sequence number has no effect.
- R9: When no store overlaps, `res_kind`=3 (cache read) and `res_linked` equals `ld_linked`: 1 selects a load-locked read, 0 a plain read.
- R10: `fwd_cnt` increments once per forward result, and `replay_cnt` increments once per replay result.
- R11: From the acceptance of a load that needs a walk until its result, `ld_ready` stays low.
- R12: A matching completion and a replay may resolve in the same cycle. The old record is then released and the new replay takes the record, whatever the two loads' ages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Block idle and able to accept a load |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | SIZE_W | Load size in bytes (1 to DATA_BYTES) |
| ld_stq_pos | input | STQ_IDX_W | Store-queue position the load sits behind |
| ld_ldq_pos | input | LDQ_IDX_W | Load-queue position of the load |
| ld_seq | input | SEQ_W | Load age tag; smaller is older |
| ld_linked | input | 1 | Load is a linked (load-locked) access |
| wb_pos | input | STQ_IDX_W | Oldest store not yet written back |
| stq_rd_pos | output | STQ_IDX_W | Store-queue read position; data is due one cycle later |
| stq_addr | input | ADDR_W | Read entry: store address |
| stq_size | input | SIZE_W | Read entry: store size in bytes |
| stq_data | input | DATA_W | Read entry: store bytes, byte 0 in the low bits |
| stq_uncache | input | 1 | Read entry: uncacheable flag |
| stq_seq | input | SEQ_W | Read entry: store sequence number |
| st_done_valid | input | 1 | A store has completed |
| st_done_seq | input | SEQ_W | Sequence number of the completed store |
| res_valid | output | 1 | One-cycle result pulse |
| res_kind | output | 2 | 1 forward, 2 replay, 3 cache read |
| res_data | output | DATA_W | Forwarded bytes |
| res_ldq_pos | output | LDQ_IDX_W | Load-queue position of the result |
| res_linked | output | 1 | Cache read uses the load-locked command |
| fwd_cnt | output | CNT_W | Forwarded-load count |
| replay_cnt | output | CNT_W | Replayed-load count |
| stall_active | output | 1 | A stall record is held |
| stall_st_seq | output | SEQ_W | Sequence number of the blocking store |
| stall_ldq_pos | output | LDQ_IDX_W | Position of the held load |
| rel_valid | output | 1 | Held load released for replay |
| rel_ldq_pos | output | LDQ_IDX_W | Position of the released load |

## Verification
The risky coincidence is a store completion that clears the stall record landing on the same clock edge as a new partial overlap that wants to write it.

The bench sets up this collision on purpose. It first establishes a stall, then issues a younger load whose single-entry walk ends in a partial overlap. It holds the matching completion for exactly the cycle in which that entry is evaluated.

It then expects three things together: a replay result, a release pulse naming the old load, and a stall record that now holds the new, younger load and its store. Random traffic mixes completions among loads, and a bench model of the record judges every outcome.

// File: rtl/stld_pkg.sv
`timescale 1ns/1ps
package stld_pkg;
  typedef enum logic [1:0] {
    RES_NONE   = 2'd0,
    RES_FWD    = 2'd1,
    RES_REPLAY = 2'd2,
    RES_CACHE  = 2'd3
  } res_kind_t;

  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_REQ  = 2'd1,
    WALK_CHK  = 2'd2
  } walk_state_t;
endpackage

// File: rtl/stld_overlap.sv
`timescale 1ns/1ps
// Range compare of one store entry against the load, plus byte extraction.
module stld_overlap #(
  parameter int ADDR_W     = 16,
  parameter int DATA_BYTES = 8,
  parameter int SIZE_W     = 4
) (
  input  logic [ADDR_W-1:0]       ld_addr,
  input  logic [SIZE_W-1:0]       ld_size,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [SIZE_W-1:0]       st_size,
  input  logic [DATA_BYTES*8-1:0] st_data,
  input  logic                    st_uncache,
  output logic                    full_hit,
  output logic                    part_hit,
  output logic [DATA_BYTES*8-1:0] fwd_data
);
  localparam int AW1   = ADDR_W + 1;
  localparam int OFF_W = $clog2(DATA_BYTES);

  logic [AW1-1:0]   ld_lo, ld_hi, st_lo, st_hi, offs;
  logic [OFF_W-1:0] off_small;
  logic             eligible, covers, touches;

  always_comb begin
    ld_lo     = {1'b0, ld_addr};
    ld_hi     = ld_lo + AW1'(ld_size);
    st_lo     = {1'b0, st_addr};
    st_hi     = st_lo + AW1'(st_size);
    eligible  = (st_size != '0) && !st_uncache;
    covers    = (ld_lo >= st_lo) && (ld_hi <= st_hi);
    touches   = (ld_lo < st_hi) && (ld_hi > st_lo);
    full_hit  = eligible && covers;
    part_hit  = eligible && touches && !covers;
    offs      = ld_lo - st_lo;
    off_small = offs[OFF_W-1:0];
  end

  always_comb begin
    fwd_data = '0;
    for (int i = 0; i < DATA_BYTES; i++) begin
      if (i < int'(ld_size) && (int'(off_small) + i) < DATA_BYTES)
        fwd_data[i*8 +: 8] = st_data[(int'(off_small) + i)*8 +: 8];
    end
  end
endmodule

// File: rtl/stld_walker.sv
`timescale 1ns/1ps
// Walks store-queue positions toward older stores and issues the result.
module stld_walker
  import stld_pkg::*;
#(
  parameter int STQ_DEPTH  = 8,
  parameter int ADDR_W     = 16,
  parameter int DATA_BYTES = 8,
  parameter int SIZE_W     = 4,
  parameter int SEQ_W      = 8,
  parameter int LDQ_IDX_W  = 4,
  parameter int CNT_W      = 16,
  parameter int STQ_IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_valid,
  output logic                    ld_ready,
  input  logic [ADDR_W-1:0]       ld_addr,
  input  logic [SIZE_W-1:0]       ld_size,
  input  logic [STQ_IDX_W-1:0]    ld_stq_pos,
  input  logic [LDQ_IDX_W-1:0]    ld_ldq_pos,
  input  logic [SEQ_W-1:0]        ld_seq,
  input  logic                    ld_linked,
  input  logic [STQ_IDX_W-1:0]    wb_pos,
  output logic [STQ_IDX_W-1:0]    stq_rd_pos,
  input  logic [SEQ_W-1:0]        stq_seq,
  output logic [ADDR_W-1:0]       cur_addr,
  output logic [SIZE_W-1:0]       cur_size,
  input  logic                    full_hit,
  input  logic                    part_hit,
  input  logic [DATA_BYTES*8-1:0] fwd_data,
  output logic                    res_valid,
  output res_kind_t               res_kind,
  output logic [DATA_BYTES*8-1:0] res_data,
  output logic [LDQ_IDX_W-1:0]    res_ldq_pos,
  output logic                    res_linked,
  output logic [CNT_W-1:0]        fwd_cnt,
  output logic [CNT_W-1:0]        replay_cnt,
  output logic                    part_evt,
  output logic [LDQ_IDX_W-1:0]    part_ldq_pos,
  output logic [SEQ_W-1:0]        part_ld_seq,
  output logic [SEQ_W-1:0]        part_st_seq
);
  walk_state_t            state;
  logic [STQ_IDX_W-1:0]   cur, stop_pos;
  logic [LDQ_IDX_W-1:0]   ldq_l;
  logic [SEQ_W-1:0]       seq_l;
  logic                   linked_l;

  function automatic logic [STQ_IDX_W-1:0] older_pos(input logic [STQ_IDX_W-1:0] p);
    return (p == '0) ? STQ_IDX_W'(STQ_DEPTH - 1) : p - 1'b1;
  endfunction

  assign ld_ready     = (state == WALK_IDLE);
  assign stq_rd_pos   = cur;
  assign part_evt     = (state == WALK_CHK) && !full_hit && part_hit;
  assign part_ldq_pos = ldq_l;
  assign part_ld_seq  = seq_l;
  assign part_st_seq  = stq_seq;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= WALK_IDLE;
      cur         <= '0;
      stop_pos    <= '0;
      cur_addr    <= '0;
      cur_size    <= '0;
      ldq_l       <= '0;
      seq_l       <= '0;
      linked_l    <= 1'b0;
      res_valid   <= 1'b0;
      res_kind    <= RES_NONE;
      res_data    <= '0;
      res_ldq_pos <= '0;
      res_linked  <= 1'b0;
      fwd_cnt     <= '0;
      replay_cnt  <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (state)
        WALK_IDLE: begin
          if (ld_valid) begin
            cur_addr <= ld_addr;
            cur_size <= ld_size;
            ldq_l    <= ld_ldq_pos;
            seq_l    <= ld_seq;
            linked_l <= ld_linked;
            stop_pos <= wb_pos;
            if (ld_stq_pos == wb_pos) begin
              res_valid   <= 1'b1;
              res_kind    <= RES_CACHE;
              res_data    <= '0;
              res_ldq_pos <= ld_ldq_pos;
              res_linked  <= ld_linked;
            end else begin
              cur   <= older_pos(ld_stq_pos);
              state <= WALK_REQ;
            end
          end
        end
        WALK_REQ: state <= WALK_CHK;
        WALK_CHK: begin
          if (full_hit) begin
            res_valid   <= 1'b1;
            res_kind    <= RES_FWD;
            res_data    <= fwd_data;
            res_ldq_pos <= ldq_l;
            res_linked  <= 1'b0;
            fwd_cnt     <= fwd_cnt + 1'b1;
            state       <= WALK_IDLE;
          end else if (part_hit) begin
            res_valid   <= 1'b1;
            res_kind    <= RES_REPLAY;
            res_data    <= '0;
            res_ldq_pos <= ldq_l;
            res_linked  <= 1'b0;
            replay_cnt  <= replay_cnt + 1'b1;
            state       <= WALK_IDLE;
          end else if (cur == stop_pos) begin
            res_valid   <= 1'b1;
            res_kind    <= RES_CACHE;
            res_data    <= '0;
            res_ldq_pos <= ldq_l;
            res_linked  <= linked_l;
            state       <= WALK_IDLE;
          end else begin
            cur   <= older_pos(cur);
            state <= WALK_REQ;
          end
        end
        default: state <= WALK_IDLE;
      endcase
    end
  end

  // R11: a load that needs a walk holds the port busy
  assert_busy_walk_R11: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready && (ld_stq_pos != wb_pos)) |=> !ld_ready);

  // R10: each forward result is counted once
  assert_fwd_count_R10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_kind == RES_FWD) |-> (fwd_cnt == CNT_W'($past(fwd_cnt) + 1'b1)));

  // R10: each replay result is counted once
  assert_replay_count_R10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_kind == RES_REPLAY) |-> (replay_cnt == CNT_W'($past(replay_cnt) + 1'b1)));
endmodule

// File: rtl/stld_stall_rec.sv
`timescale 1ns/1ps
// Holds the oldest replayed load and the store it waits on.
module stld_stall_rec #(
  parameter int SEQ_W     = 8,
  parameter int LDQ_IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 part_evt,
  input  logic [LDQ_IDX_W-1:0] part_ldq_pos,
  input  logic [SEQ_W-1:0]     part_ld_seq,
  input  logic [SEQ_W-1:0]     part_st_seq,
  input  logic                 done_valid,
  input  logic [SEQ_W-1:0]     done_seq,
  output logic                 stall_active,
  output logic [SEQ_W-1:0]     stall_st_seq,
  output logic [LDQ_IDX_W-1:0] stall_ldq_pos,
  output logic                 rel_valid,
  output logic [LDQ_IDX_W-1:0] rel_ldq_pos
);
  logic [SEQ_W-1:0] stall_ld_seq;
  logic             clear_hit, still_held, take;

  assign clear_hit  = done_valid && stall_active && (done_seq == stall_st_seq);
  assign still_held = stall_active && !clear_hit;
  assign take       = part_evt && (!still_held || (part_ld_seq < stall_ld_seq));

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_active  <= 1'b0;
      stall_st_seq  <= '0;
      stall_ldq_pos <= '0;
      stall_ld_seq  <= '0;
      rel_valid     <= 1'b0;
      rel_ldq_pos   <= '0;
    end else begin
      rel_valid <= clear_hit;
      if (clear_hit) rel_ldq_pos <= stall_ldq_pos;
      if (take) begin
        stall_active  <= 1'b1;
        stall_st_seq  <= part_st_seq;
        stall_ldq_pos <= part_ldq_pos;
        stall_ld_seq  <= part_ld_seq;
      end else if (clear_hit) begin
        stall_active <= 1'b0;
      end
    end
  end

  // R8: a release only follows a held record
  assert_release_needs_stall_R8: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> $past(stall_active));

  // R7: without a release, the held load can only become older
  assert_older_replaces_R7: assert property (@(posedge clk) disable iff (rst)
    (stall_active && $past(stall_active) && !rel_valid) |-> (stall_ld_seq <= $past(stall_ld_seq)));

  // R7: a partial overlap always leaves a record held
  assert_partial_sets_R7: assert property (@(posedge clk) disable iff (rst)
    $past(part_evt) |-> stall_active);
endmodule

// File: rtl/stld_fwd_check.sv
`timescale 1ns/1ps
module stld_fwd_check
  import stld_pkg::*;
#(
  parameter int STQ_DEPTH  = 8,
  parameter int ADDR_W     = 16,
  parameter int DATA_BYTES = 8,
  parameter int SEQ_W      = 8,
  parameter int LDQ_IDX_W  = 4,
  parameter int CNT_W      = 16,
  localparam int STQ_IDX_W = $clog2(STQ_DEPTH),
  localparam int SIZE_W    = $clog2(DATA_BYTES) + 1,
  localparam int DATA_W    = DATA_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_valid,
  output logic                 ld_ready,
  input  logic [ADDR_W-1:0]    ld_addr,
  input  logic [SIZE_W-1:0]    ld_size,
  input  logic [STQ_IDX_W-1:0] ld_stq_pos,
  input  logic [LDQ_IDX_W-1:0] ld_ldq_pos,
  input  logic [SEQ_W-1:0]     ld_seq,
  input  logic                 ld_linked,
  input  logic [STQ_IDX_W-1:0] wb_pos,
  output logic [STQ_IDX_W-1:0] stq_rd_pos,
  input  logic [ADDR_W-1:0]    stq_addr,
  input  logic [SIZE_W-1:0]    stq_size,
  input  logic [DATA_W-1:0]    stq_data,
  input  logic                 stq_uncache,
  input  logic [SEQ_W-1:0]     stq_seq,
  input  logic                 st_done_valid,
  input  logic [SEQ_W-1:0]     st_done_seq,
  output logic                 res_valid,
  output logic [1:0]           res_kind,
  output logic [DATA_W-1:0]    res_data,
  output logic [LDQ_IDX_W-1:0] res_ldq_pos,
  output logic                 res_linked,
  output logic [CNT_W-1:0]     fwd_cnt,
  output logic [CNT_W-1:0]     replay_cnt,
  output logic                 stall_active,
  output logic [SEQ_W-1:0]     stall_st_seq,
  output logic [LDQ_IDX_W-1:0] stall_ldq_pos,
  output logic                 rel_valid,
  output logic [LDQ_IDX_W-1:0] rel_ldq_pos
);
  logic [ADDR_W-1:0]    cur_addr;
  logic [SIZE_W-1:0]    cur_size;
  logic                 full_hit, part_hit, part_evt;
  logic [DATA_W-1:0]    fwd_data;
  logic [LDQ_IDX_W-1:0] part_ldq_pos;
  logic [SEQ_W-1:0]     part_ld_seq, part_st_seq;
  res_kind_t            kind_e;

  assign res_kind = kind_e;

  stld_overlap #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .SIZE_W(SIZE_W)) u_overlap (
    .ld_addr(cur_addr), .ld_size(cur_size),
    .st_addr(stq_addr), .st_size(stq_size), .st_data(stq_data), .st_uncache(stq_uncache),
    .full_hit(full_hit), .part_hit(part_hit), .fwd_data(fwd_data)
  );

  stld_walker #(
    .STQ_DEPTH(STQ_DEPTH), .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .SIZE_W(SIZE_W),
    .SEQ_W(SEQ_W), .LDQ_IDX_W(LDQ_IDX_W), .CNT_W(CNT_W), .STQ_IDX_W(STQ_IDX_W)
  ) u_walker (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_size(ld_size),
    .ld_stq_pos(ld_stq_pos), .ld_ldq_pos(ld_ldq_pos), .ld_seq(ld_seq), .ld_linked(ld_linked),
    .wb_pos(wb_pos), .stq_rd_pos(stq_rd_pos), .stq_seq(stq_seq),
    .cur_addr(cur_addr), .cur_size(cur_size),
    .full_hit(full_hit), .part_hit(part_hit), .fwd_data(fwd_data),
    .res_valid(res_valid), .res_kind(kind_e), .res_data(res_data),
    .res_ldq_pos(res_ldq_pos), .res_linked(res_linked),
    .fwd_cnt(fwd_cnt), .replay_cnt(replay_cnt),
    .part_evt(part_evt), .part_ldq_pos(part_ldq_pos),
    .part_ld_seq(part_ld_seq), .part_st_seq(part_st_seq)
  );

  stld_stall_rec #(.SEQ_W(SEQ_W), .LDQ_IDX_W(LDQ_IDX_W)) u_stall (
    .clk(clk), .rst(rst),
    .part_evt(part_evt), .part_ldq_pos(part_ldq_pos),
    .part_ld_seq(part_ld_seq), .part_st_seq(part_st_seq),
    .done_valid(st_done_valid), .done_seq(st_done_seq),
    .stall_active(stall_active), .stall_st_seq(stall_st_seq),
    .stall_ldq_pos(stall_ldq_pos), .rel_valid(rel_valid), .rel_ldq_pos(rel_ldq_pos)
  );
endmodule

// File: tb/stld_fwd_check_tb_top.sv
`timescale 1ns/1ps
module stld_fwd_check_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        ld_valid, ld_ready, ld_linked;
  logic [15:0] ld_addr;
  logic [3:0]  ld_size;
  logic [2:0]  ld_stq_pos, wb_pos, stq_rd_pos;
  logic [3:0]  ld_ldq_pos;
  logic [7:0]  ld_seq;
  logic [15:0] stq_addr;
  logic [3:0]  stq_size;
  logic [63:0] stq_data;
  logic        stq_uncache;
  logic [7:0]  stq_seq;
  logic        st_done_valid;
  logic [7:0]  st_done_seq;
  logic        res_valid, res_linked;
  logic [1:0]  res_kind;
  logic [63:0] res_data;
  logic [3:0]  res_ldq_pos;
  logic [15:0] fwd_cnt, replay_cnt;
  logic        stall_active, rel_valid;
  logic [7:0]  stall_st_seq;
  logic [3:0]  stall_ldq_pos, rel_ldq_pos;

  always #4 clk = ~clk;  // 125 MHz

  stld_fwd_check dut_i (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .ld_size(ld_size), .ld_stq_pos(ld_stq_pos), .ld_ldq_pos(ld_ldq_pos), .ld_seq(ld_seq),
    .ld_linked(ld_linked), .wb_pos(wb_pos), .stq_rd_pos(stq_rd_pos), .stq_addr(stq_addr),
    .stq_size(stq_size), .stq_data(stq_data), .stq_uncache(stq_uncache), .stq_seq(stq_seq),
    .st_done_valid(st_done_valid), .st_done_seq(st_done_seq), .res_valid(res_valid),
    .res_kind(res_kind), .res_data(res_data), .res_ldq_pos(res_ldq_pos),
    .res_linked(res_linked), .fwd_cnt(fwd_cnt), .replay_cnt(replay_cnt),
    .stall_active(stall_active), .stall_st_seq(stall_st_seq), .stall_ldq_pos(stall_ldq_pos),
    .rel_valid(rel_valid), .rel_ldq_pos(rel_ldq_pos)
  );

  // store-queue model with a registered read
  logic [15:0] m_addr [8];
  logic [3:0]  m_size [8];
  logic [63:0] m_data [8];
  logic        m_unc  [8];
  logic [7:0]  m_seq  [8];

  always_ff @(posedge clk) begin
    stq_addr    <= m_addr[stq_rd_pos];
    stq_size    <= m_size[stq_rd_pos];
    stq_data    <= m_data[stq_rd_pos];
    stq_uncache <= m_unc[stq_rd_pos];
    stq_seq     <= m_seq[stq_rd_pos];
  end

  int n_chk = 0, n_fail = 0;
  int exp_fwd = 0, exp_rep = 0;
  bit finished = 0;
  bit         e_act = 0;
  logic [7:0] e_sst = '0, e_sld = '0;
  logic [3:0] e_slq = '0;

  task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ent(input int i, input logic [15:0] a, input logic [3:0] s,
                         input logic [63:0] d, input bit u, input logic [7:0] q);
    m_addr[i] = a; m_size[i] = s; m_data[i] = d; m_unc[i] = u; m_seq[i] = q;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 8; i++) set_ent(i, 16'h0, 4'd0, 64'h0, 1'b0, 8'h0);
  endtask

  // expected outcome: kind 1 forward, 2 replay, 3 cache
  function automatic void ref_walk(input logic [15:0] la, input logic [3:0] ls,
                                   input logic [2:0] sp, input logic [2:0] wb,
                                   output logic [1:0] kind, output logic [63:0] data,
                                   output logic [7:0] sseq);
    int idx, lo, hi, so, sh, off;
    kind = 2'd3; data = '0; sseq = '0;
    if (sp == wb) return;
    idx = int'(sp);
    for (int n = 0; n < 8; n++) begin
      idx = (idx == 0) ? 7 : idx - 1;
      if (m_size[idx] != 0 && !m_unc[idx]) begin
        lo = int'(la); hi = lo + int'(ls);
        so = int'(m_addr[idx]); sh = so + int'(m_size[idx]);
        if (lo >= so && hi <= sh) begin
          kind = 2'd1; off = lo - so;
          for (int b = 0; b < int'(ls); b++) data[b*8 +: 8] = m_data[idx][(off+b)*8 +: 8];
          return;
        end else if (lo < sh && hi > so) begin
          kind = 2'd2; sseq = m_seq[idx];
          return;
        end
      end
      if (idx == int'(wb)) return;
    end
  endfunction

  task automatic do_load(input logic [15:0] la, input logic [3:0] ls, input logic [2:0] sp,
                         input logic [3:0] lq, input logic [7:0] sq, input bit lk,
                         input logic [2:0] wb, input string tag);
    logic [1:0] ek; logic [63:0] ed; logic [7:0] es; int t;
    ref_walk(la, ls, sp, wb, ek, ed, es);
    @(negedge clk);
    ld_addr = la; ld_size = ls; ld_stq_pos = sp; ld_ldq_pos = lq;
    ld_seq = sq; ld_linked = lk; wb_pos = wb; ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    if (sp != wb) chk_eq({tag, " R11 busy"}, 64'(ld_ready), 64'd0);
    else          chk_eq({tag, " R3 immediate"}, 64'(res_valid), 64'd1);
    t = 0;
    while (!res_valid && t < 100) begin @(negedge clk); t++; end
    chk_eq({tag, " R2 kind"}, 64'(res_kind), 64'(ek));
    chk_eq({tag, " R6 pos"}, 64'(res_ldq_pos), 64'(lq));
    if (ek == 2'd1) begin
      exp_fwd++;
      chk_eq({tag, " R5 data"}, res_data, ed);
    end else if (ek == 2'd2) begin
      exp_rep++;
      if (!e_act || sq < e_sld) begin
        e_act = 1; e_sst = es; e_slq = lq; e_sld = sq;
      end
    end else begin
      chk_eq({tag, " R9 linked"}, 64'(res_linked), 64'(lk));
    end
    chk_eq({tag, " R10 fwd"}, 64'(fwd_cnt), 64'(exp_fwd));
    chk_eq({tag, " R10 replay"}, 64'(replay_cnt), 64'(exp_rep));
    chk_eq({tag, " R7 active"}, 64'(stall_active), 64'(e_act));
    if (e_act) begin
      chk_eq({tag, " R7 store"}, 64'(stall_st_seq), 64'(e_sst));
      chk_eq({tag, " R7 load"}, 64'(stall_ldq_pos), 64'(e_slq));
    end
  endtask

  task automatic do_done(input logic [7:0] s, input string tag);
    bit hit; logic [3:0] lq;
    hit = e_act && (s == e_sst); lq = e_slq;
    @(negedge clk);
    st_done_valid = 1'b1; st_done_seq = s;
    @(negedge clk);
    st_done_valid = 1'b0;
    chk_eq({tag, " R8 release"}, 64'(rel_valid), 64'(hit));
    if (hit) begin
      chk_eq({tag, " R8 pos"}, 64'(rel_ldq_pos), 64'(lq));
      e_act = 0;
    end
    chk_eq({tag, " R8 active"}, 64'(stall_active), 64'(e_act));
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    rst = 1'b1; ld_valid = 0; ld_addr = 0; ld_size = 0; ld_stq_pos = 0; ld_ldq_pos = 0;
    ld_seq = 0; ld_linked = 0; wb_pos = 0; st_done_valid = 0; st_done_seq = 0;
    clear_mem();
    repeat (3) @(negedge clk);
    chk_eq("R1 ready", 64'(ld_ready), 64'd1);
    chk_eq("R1 res", 64'(res_valid), 64'd0);
    chk_eq("R1 stall", 64'(stall_active), 64'd0);
    chk_eq("R1 rel", 64'(rel_valid), 64'd0);
    chk_eq("R1 counts", 64'({fwd_cnt, replay_cnt}), 64'd0);
    rst = 1'b0;

    // R3: start equals writeback position, linked load
    do_load(16'h10, 4'd4, 3'd3, 4'd1, 8'h05, 1'b1, 3'd3, "R3 empty walk");
    // R9: all entries empty
    do_load(16'h10, 4'd4, 3'd5, 4'd2, 8'h06, 1'b0, 3'd2, "R9 plain read");
    // R5: forward at byte offset 3
    set_ent(4, 16'h10, 4'd8, 64'h8877665544332211, 1'b0, 8'h11);
    do_load(16'h13, 4'd2, 3'd5, 4'd3, 8'h07, 1'b0, 3'd0, "R5 offset");
    n_chk++;
    if (res_data !== 64'h5544) begin
      n_fail++; $display("FAIL R5 literal actual=%0h expected=5544", res_data);
    end
    // R4: zero-size and uncacheable entries are passed over
    set_ent(4, 16'h10, 4'd0, 64'hFFFF, 1'b0, 8'h12);
    set_ent(3, 16'h10, 4'd8, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1, 8'h13);
    set_ent(2, 16'h10, 4'd8, 64'h0102030405060708, 1'b0, 8'h14);
    do_load(16'h10, 4'd4, 3'd5, 4'd4, 8'h08, 1'b0, 3'd0, "R4 skip");
    // R2: nearest partial wins over older full cover; R6 replay
    clear_mem();
    set_ent(4, 16'h12, 4'd2, 64'h0, 1'b0, 8'h30);
    set_ent(3, 16'h10, 4'd8, 64'h1, 1'b0, 8'h31);
    do_load(16'h10, 4'd4, 3'd5, 4'd5, 8'h20, 1'b0, 3'd0, "R2 nearest");
    // R7: younger does not replace, older does
    do_load(16'h10, 4'd4, 3'd5, 4'd6, 8'h40, 1'b0, 3'd0, "R7 younger");
    do_load(16'h10, 4'd4, 3'd5, 4'd7, 8'h10, 1'b0, 3'd0, "R7 older");
    // R8: other sequence ignored, matching one releases
    do_done(8'h99, "R8 mismatch");
    do_done(8'h30, "R8 match");
    // R2 wrap and R3 stop
    clear_mem();
    set_ent(7, 16'h20, 4'd4, 64'hCAFE_F00D, 1'b0, 8'h41);
    do_load(16'h21, 4'd2, 3'd1, 4'd8, 8'h09, 1'b0, 3'd6, "R2 wrap");
    clear_mem();
    set_ent(5, 16'h20, 4'd4, 64'h1234, 1'b0, 8'h42);
    do_load(16'h20, 4'd4, 3'd1, 4'd9, 8'h0A, 1'b0, 3'd6, "R3 beyond wb");

    // R12: completion and new partial on the same edge
    clear_mem();
    set_ent(2, 16'h40, 4'd4, 64'h0, 1'b0, 8'h30);
    do_load(16'h42, 4'd4, 3'd3, 4'd5, 8'h20, 1'b0, 3'd2, "R12 setup");
    m_seq[2] = 8'h31;
    @(negedge clk);
    ld_addr = 16'h42; ld_size = 4'd4; ld_stq_pos = 3'd3; ld_ldq_pos = 4'd6;
    ld_seq = 8'h50; ld_linked = 0; wb_pos = 3'd2; ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    @(negedge clk);
    st_done_valid = 1'b1; st_done_seq = 8'h30;
    @(negedge clk);
    st_done_valid = 1'b0;
    exp_rep++;
    chk_eq("R12 replay", 64'({res_valid, res_kind}), 64'({1'b1, 2'd2}));
    chk_eq("R12 release", 64'({rel_valid, rel_ldq_pos}), 64'({1'b1, 4'd5}));
    chk_eq("R12 new record", 64'({stall_active, stall_st_seq, stall_ldq_pos}),
           64'({1'b1, 8'h31, 4'd6}));
    chk_eq("R12 replay count", 64'(replay_cnt), 64'(exp_rep));
    e_act = 1; e_sst = 8'h31; e_slq = 4'd6; e_sld = 8'h50;

    // random traffic
    for (int it = 0; it < 400; it++) begin
      logic [3:0] lsz;
      for (int i = 0; i < 8; i++) begin
        logic [3:0] ssz;
        case ($urandom_range(0, 4))
          0: ssz = 4'd0; 1: ssz = 4'd1; 2: ssz = 4'd2; 3: ssz = 4'd4; default: ssz = 4'd8;
        endcase
        set_ent(i, 16'($urandom_range(0, 24)), ssz, {$urandom, $urandom},
                ($urandom_range(0, 7) == 0), 8'($urandom));
      end
      case ($urandom_range(0, 3))
        0: lsz = 4'd1; 1: lsz = 4'd2; 2: lsz = 4'd4; default: lsz = 4'd8;
      endcase
      do_load(16'($urandom_range(0, 28)), lsz, 3'($urandom), 4'($urandom), 8'($urandom),
              1'($urandom), 3'($urandom), "R2 random");
      if (it % 3 == 0)
        do_done(($urandom_range(0, 1) == 0) ? e_sst : 8'($urandom), "R8 random");
    end
    finish_run();
  end
endmodule